// File: doc/BRIEF.md
# Counter-Instruction Stored-Program Interpreter

This block is a very small stored-program machine. Its program, the program's operands and its data share one 32-word by 16-bit memory. A hard-wired sequencer fetches, decodes and executes the program one memory access per clock. The program counter, the instruction word and a scratch word are not separate registers. They are ordinary memory words at addresses 1, 2 and 3. A program can therefore read or overwrite them like any other word, including its own instruction words.

The machine knows four operations: stop, increment a register, decrement a register (never below zero), and branch when a register is zero. The opcode is not decoded through a table. The sequencer tests the stored instruction word for zero, then decrements it in memory and tests again, up to three times. The number of decrements taken identifies the operation. A word that is still non-zero after the third decrement is rejected as invalid.

In use, the surrounding logic fills memory through the load port while the machine is not running. That includes the starting program counter at address 1. It then pulses `start` and waits for `halted` or `error`. Any word can be read back at any time through the read-back port.

Top module: `tally_interp`

## Requirements
- R1: Memory holds 2^ADDR_W words of DATA_W bits. Address 1 is the program counter, address 2 the instruction word, address 3 scratch, and all are ordinary words. Any word used as an address selects with its low ADDR_W bits, and all arithmetic wraps modulo 2^DATA_W.
- R2: Opcode values: 0 stop, 1 increment, 2 decrement, 3 branch-if-zero. Increment and decrement occupy two words (opcode, register number). Branch occupies three words (opcode, register number, target).
- R3: An opcode above 3 raises `error` 10 cycles after the start edge of that instruction's fetch. Word 2 then holds the opcode minus 3, and the program counter is unchanged.
- R4: A stop opcode raises `halted` 4 cycles after its fetch begins. The program counter keeps pointing at the stop word, and word 2 holds 0.
- R5: Increment takes 15 cycles. It advances the PC, copies the operand into word 2, writes the incremented target value into word 3 and into the target, and advances the PC again. 0xFFFF wraps to 0.
- R6: Decrement behaves like increment but takes 17 cycles. A target already at 0 stays at 0.
- R7: Branch takes 20 cycles on both paths. It advances the PC, copies the operand into word 2, and copies the tested value into word 3. A non-zero value advances the PC twice more. A zero value advances the PC once and then loads it from the word it points at.
- R8: A `start` pulse while idle, halted or in error begins fetch at the PC stored in memory on the next cycle. A `start` pulse while busy has no effect.
- R9: Load-port writes take effect only while `busy` is low. While busy they are ignored.
- R10: Writes made by the program to the PC, to word 2 or to its own instruction words are seen by the following fetch.
- R11: After reset `busy`, `halted` and `error` are low. `halted` and `error` stay high until the next `start`.
- R12: `rd_data` always shows the word at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_addr | input | ADDR_W | Load-port word address |
| ld_data | input | DATA_W | Load-port write data |
| start | input | 1 | Run request pulse |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | DATA_W | Read-back data |
| busy | output | 1 | Program is running |
| halted | output | 1 | Stopped on a stop opcode |
| error | output | 1 | Stopped on an invalid opcode |

## Verification
The bench targets the following corner cases:
- Both branch paths. A design that mixed up the step counts would fetch from the wrong word.
- An increment of the PC word itself, and a program that rewrites its own later opcode. A design that cached the PC or the instruction would run the stale program.
- Increment at the word's maximum, decrement at zero, and opcodes 4 and 0xFFFF. Misplaced decode limits would either run garbage or leave the wrong residue in word 2.
- A second `start` and a load-port write issued mid-run. A design that let either through would restart the fetch or corrupt a data word.

// File: rtl/tally_pkg.sv
package tally_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_F_PC, S_F_WORD, S_F_IR, S_TEST, S_DECR,
    S_PC_RD, S_PC_WR, S_O_PTR, S_O_IR, S_O_VAL, S_O_SCR, S_O_BACK,
    S_J_RD, S_J_WR, S_HALT, S_ERR
  } st_e;

  typedef enum logic [1:0] {
    K_HALT = 2'd0,
    K_INC  = 2'd1,
    K_DEC  = 2'd2,
    K_JZ   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    AF_OPER,
    AF_FETCH,
    AF_JUMP
  } after_e;

  localparam int unsigned PC_LOC  = 1;
  localparam int unsigned IR_LOC  = 2;
  localparam int unsigned SCR_LOC = 3;

endpackage

// File: rtl/tally_rst_sync.sv
module tally_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tally_mem.sv
module tally_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

  // R1: a write is visible at its address on the next cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tally_seq.sv
module tally_seq
  import tally_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              halted,
  output logic              error
);
  localparam logic [ADDR_W-1:0] A_PC  = ADDR_W'(PC_LOC);
  localparam logic [ADDR_W-1:0] A_IR  = ADDR_W'(IR_LOC);
  localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(SCR_LOC);
  localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO  = '0;
  localparam logic [DATA_W-1:0] TOP   = '1;
  localparam logic [1:0]        LAST_K = 2'd3;

  st_e               st_q, st_d;
  logic [DATA_W-1:0] pc_q, pc_d, dat_q, dat_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  kind_e             kind_q, kind_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              twice_q, twice_d;
  after_e            aft_q, aft_d;
  logic              pc_en, dat_en, tgt_en;

  always_comb begin
    st_d = st_q;  pc_d = pc_q;  dat_d = dat_q;  tgt_d = tgt_q;
    kind_d = kind_q;  cnt_d = cnt_q;  twice_d = twice_q;  aft_d = aft_q;
    pc_en = 1'b0;  dat_en = 1'b0;  tgt_en = 1'b0;
    mem_raddr = A_PC;  mem_we = 1'b0;  mem_waddr = A_IR;  mem_wdata = dat_q;
    unique case (st_q)
      S_IDLE, S_HALT, S_ERR: if (start) st_d = S_F_PC;
      S_F_PC: begin
        mem_raddr = A_PC;  pc_d = mem_rdata;  pc_en = 1'b1;  st_d = S_F_WORD;
      end
      S_F_WORD: begin
        mem_raddr = pc_q[ADDR_W-1:0];  dat_d = mem_rdata;  dat_en = 1'b1;
        st_d = S_F_IR;
      end
      S_F_IR: begin
        mem_we = 1'b1;  mem_waddr = A_IR;  mem_wdata = dat_q;
        cnt_d = 2'd0;  st_d = S_TEST;
      end
      S_TEST: begin
        mem_raddr = A_IR;  dat_d = mem_rdata;  dat_en = 1'b1;
        if (mem_rdata == ZERO) begin
          if (cnt_q == 2'd0) st_d = S_HALT;
          else begin
            kind_d = kind_e'(cnt_q);  twice_d = 1'b0;  aft_d = AF_OPER;
            st_d = S_PC_RD;
          end
        end else if (cnt_q == LAST_K) st_d = S_ERR;
        else st_d = S_DECR;
      end
      S_DECR: begin
        mem_we = 1'b1;  mem_waddr = A_IR;  mem_wdata = dat_q - ONE;
        cnt_d = cnt_q + 2'd1;  st_d = S_TEST;
      end
      S_PC_RD: begin
        mem_raddr = A_PC;  pc_d = mem_rdata;  pc_en = 1'b1;  st_d = S_PC_WR;
      end
      S_PC_WR: begin
        mem_we = 1'b1;  mem_waddr = A_PC;  mem_wdata = pc_q + ONE;
        pc_d = pc_q + ONE;  pc_en = 1'b1;
        if (twice_q) begin
          twice_d = 1'b0;  st_d = S_PC_RD;
        end else begin
          case (aft_q)
            AF_OPER: st_d = S_O_PTR;
            AF_JUMP: st_d = S_J_RD;
            default: st_d = S_F_PC;
          endcase
        end
      end
      S_O_PTR: begin
        mem_raddr = pc_q[ADDR_W-1:0];  dat_d = mem_rdata;  dat_en = 1'b1;
        tgt_d = mem_rdata[ADDR_W-1:0];  tgt_en = 1'b1;  st_d = S_O_IR;
      end
      S_O_IR: begin
        mem_we = 1'b1;  mem_waddr = A_IR;  mem_wdata = dat_q;  st_d = S_O_VAL;
      end
      S_O_VAL: begin
        mem_raddr = tgt_q;  dat_en = 1'b1;
        case (kind_q)
          K_INC:   dat_d = mem_rdata + ONE;
          K_DEC:   dat_d = (mem_rdata == ZERO) ? ZERO : mem_rdata - ONE;
          default: dat_d = mem_rdata;
        endcase
        st_d = S_O_SCR;
      end
      S_O_SCR: begin
        mem_we = 1'b1;  mem_waddr = A_SCR;  mem_wdata = dat_q;
        if (kind_q == K_JZ) begin
          st_d = S_PC_RD;
          if (dat_q != ZERO) begin
            twice_d = 1'b1;  aft_d = AF_FETCH;
          end else begin
            twice_d = 1'b0;  aft_d = AF_JUMP;
          end
        end else st_d = S_O_BACK;
      end
      S_O_BACK: begin
        mem_we = 1'b1;  mem_waddr = tgt_q;  mem_wdata = dat_q;
        twice_d = 1'b0;  aft_d = AF_FETCH;  st_d = S_PC_RD;
      end
      S_J_RD: begin
        mem_raddr = pc_q[ADDR_W-1:0];  dat_d = mem_rdata;  dat_en = 1'b1;
        st_d = S_J_WR;
      end
      S_J_WR: begin
        mem_we = 1'b1;  mem_waddr = A_PC;  mem_wdata = dat_q;  st_d = S_F_PC;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  pc_q <= '0;  dat_q <= '0;  tgt_q <= '0;
      kind_q <= K_HALT;  cnt_q <= '0;  twice_q <= 1'b0;  aft_q <= AF_FETCH;
    end else begin
      st_q <= st_d;  kind_q <= kind_d;  cnt_q <= cnt_d;
      twice_q <= twice_d;  aft_q <= aft_d;
      if (pc_en)  pc_q  <= pc_d;
      if (dat_en) dat_q <= dat_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  assign busy   = !(st_q inside {S_IDLE, S_HALT, S_ERR});
  assign halted = (st_q == S_HALT);
  assign error  = (st_q == S_ERR);

  // R8: a start outside a run launches a fetch
  p_start_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (st_q == S_F_PC));
  // R11: a stop state holds without a new start
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted);
  // R3: the decode loop never decrements more than three times
  p_decode_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DECR) |-> (cnt_q < LAST_K));
  // R5: increment of the top value stores zero
  p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_O_SCR && kind_q == K_INC && $past(mem_rdata) == TOP)
      |-> (mem_we && mem_wdata == ZERO));
  // R6: decrement of zero stores zero
  p_dec_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_O_SCR && kind_q == K_DEC && $past(mem_rdata) == ZERO)
      |-> (mem_we && mem_wdata == ZERO));
endmodule

// File: rtl/tally_interp.sv
module tally_interp #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              halted,
  output logic              error
);
  logic              rst_n_s;
  logic [ADDR_W-1:0] seq_raddr, seq_waddr, mem_waddr;
  logic [DATA_W-1:0] seq_rdata, seq_wdata, mem_wdata;
  logic              seq_we, mem_we, ld_ok;

  tally_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  tally_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .mem_rdata(seq_rdata), .mem_raddr(seq_raddr),
    .mem_we(seq_we), .mem_waddr(seq_waddr), .mem_wdata(seq_wdata),
    .busy(busy), .halted(halted), .error(error)
  );

  assign ld_ok     = ld_en && !busy;
  assign mem_we    = seq_we || ld_ok;
  assign mem_waddr = seq_we ? seq_waddr : ld_addr;
  assign mem_wdata = seq_we ? seq_wdata : ld_data;

  tally_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n_s),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(seq_raddr), .rdata_a(seq_rdata),
    .raddr_b(rd_addr), .rdata_b(rd_data)
  );

  // R9: the load port cannot write while a program runs
  p_load_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ld_en && busy && !seq_we) |-> !mem_we);
  // R11: at most one status output is high
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({busy, halted, error}));
endmodule

// File: tb/tally_interp_tb_top.sv
module tally_interp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, ld_en, start;
  logic [4:0]  ld_addr, rd_addr;
  logic [15:0] ld_data, rd_data;
  logic        busy, halted, error;
  int          checks = 0, errors = 0;
  logic [15:0] img   [32];
  logic [15:0] ref_m [32];

  always #5 clk = ~clk;

  tally_interp dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .halted(halted), .error(error)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int a = 0; a < 32; a++) img[a] = 16'h0;
  endtask

  task automatic load_img();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      ld_en = 1'b1;  ld_addr = 5'(a);  ld_data = img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Architectural reference: one instruction per pass, cycle costs per requirement
  task automatic model(output int n, output bit err);
    logic [15:0] pc, ir, p, h, v, mv;
    n = 0;  err = 1'b0;
    for (int step = 0; step < 4000; step++) begin
      pc = ref_m[1];  ir = ref_m[pc[4:0]];  ref_m[2] = ir;
      if (ir == 16'd0) begin n += 4; return; end
      if (ir > 16'd3) begin ref_m[2] = ir - 16'd3; n += 10; err = 1'b1; return; end
      ref_m[2] = 16'd0;
      ref_m[1] = ref_m[1] + 16'd1;
      p = ref_m[1];  h = ref_m[p[4:0]];  ref_m[2] = h;  v = ref_m[h[4:0]];
      if (ir == 16'd1)      begin mv = v + 16'd1; n += 15; end
      else if (ir == 16'd2) begin mv = (v == 16'd0) ? 16'd0 : v - 16'd1; n += 17; end
      else                  begin mv = v; n += 20; end
      ref_m[3] = mv;
      if (ir != 16'd3) begin
        ref_m[h[4:0]] = mv;
        ref_m[1] = ref_m[1] + 16'd1;
      end else if (v != 16'd0) begin
        ref_m[1] = ref_m[1] + 16'd2;
      end else begin
        ref_m[1] = ref_m[1] + 16'd1;
        ref_m[1] = ref_m[ref_m[1][4:0]];
      end
    end
  endtask

  task automatic run(input string tag, input int inj_start, input int inj_load);
    int n;  bit er;  logic [2:0] exp_st;
    for (int a = 0; a < 32; a++) ref_m[a] = img[a];
    model(n, er);
    @(negedge clk);  start = 1'b1;
    @(negedge clk);  start = 1'b0;
    for (int j = 0; j <= n; j++) begin
      if (j > 0) @(negedge clk);
      exp_st = (j < n) ? 3'b100 : (er ? 3'b001 : 3'b010);
      chk({busy, halted, error} == exp_st, tag, {29'd0, busy, halted, error}, {29'd0, exp_st});
      start = (j == inj_start);
      if (j == inj_load) begin
        ld_en = 1'b1;  ld_addr = 5'd30;  ld_data = 16'h1234;
      end else ld_en = 1'b0;
    end
    start = 1'b0;  ld_en = 1'b0;
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(rd_data == ref_m[a], {tag, " R12 R1 word"}, {16'd0, rd_data}, {16'd0, ref_m[a]});
    end
    for (int a = 0; a < 32; a++) img[a] = ref_m[a];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;  errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;  ld_en = 1'b0;  start = 1'b0;
    ld_addr = '0;  ld_data = '0;  rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: quiet status after reset
    chk({busy, halted, error} == 3'b000, "R11 reset", {29'd0, busy, halted, error}, 32'd0);

    // R7 R6 R5 R2: move loop with both branch paths
    clear_img();
    img[1] = 16'd5;
    img[5] = 16'd3;  img[6] = 16'd18; img[7] = 16'd15;
    img[8] = 16'd2;  img[9] = 16'd18;
    img[10] = 16'd1; img[11] = 16'd19;
    img[12] = 16'd3; img[13] = 16'd0; img[14] = 16'd5;
    img[15] = 16'd0; img[18] = 16'd3;
    load_img();
    run("R7 R2 move loop", -1, -1);

    // R4: immediate stop, then R8 restart from the halted state
    clear_img();
    img[1] = 16'd9;  img[9] = 16'd0;  img[2] = 16'h55;
    load_img();
    run("R4 stop", -1, -1);
    run("R8 restart", -1, -1);

    // R3: smallest invalid opcode, then the largest
    clear_img();
    img[1] = 16'd6;  img[6] = 16'd4;
    load_img();
    run("R3 opcode 4", -1, -1);
    img[6] = 16'hFFFF;
    load_img();
    run("R3 opcode max", -1, -1);

    // R5 R6: wrap at the top, floor at zero, ordinary decrement
    clear_img();
    img[1] = 16'd5;
    img[5] = 16'd1;  img[6] = 16'd20;
    img[7] = 16'd2;  img[8] = 16'd21;
    img[9] = 16'd2;  img[10] = 16'd22;
    img[11] = 16'd0;
    img[20] = 16'hFFFF;  img[21] = 16'd0;  img[22] = 16'd5;
    load_img();
    run("R5 R6 wrap floor", -1, -1);

    // R10: program bumps its own PC, rewrites a later opcode, edits word 2
    clear_img();
    img[1] = 16'd5;
    img[5] = 16'd1;  img[6] = 16'd1;
    img[8] = 16'd1;  img[9] = 16'd10;
    img[10] = 16'd0; img[11] = 16'd2;
    img[12] = 16'd0;
    load_img();
    run("R10 self modify", -1, -1);

    // R9 R8: load and start issued mid-run are ignored
    clear_img();
    img[1] = 16'd5;
    img[5] = 16'd3;  img[6] = 16'd18; img[7] = 16'd15;
    img[8] = 16'd2;  img[9] = 16'd18;
    img[10] = 16'd1; img[11] = 16'd19;
    img[12] = 16'd3; img[13] = 16'd0; img[14] = 16'd5;
    img[15] = 16'd0; img[18] = 16'd2;
    load_img();
    run("R9 R8 busy ignore", 3, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule